// File: doc/BRIEF.md
# Class-H Supply Mode Controller

This block sets the operating mode of a headphone charge pump from the level of the audio going to the amplifier. A sample-valid strobe marks each new signed two's-complement sample. The block takes the magnitude of each sample and compares it with two programmable levels. The lower level picks the pump switching frequency and the upper level picks the supply rail (half or full). Rail increases take effect at once. A decrease waits until the signal has stayed quiet for a programmable number of sample ticks, so the rail does not pump up and down on every zero crossing.

A simple parallel write port holds the two levels, the hold length and a control word. The control word can turn off the signal-driven behaviour and pin the rail to either setting. In that static mode the switching frequency is held high.

Top module: `chsup_ctrl`

## Requirements
- R1: After reset, `rail_full` is 1 and `fsw_high` is 1, the controller is in dynamic mode and the quiet-tick count is zero.
- R2: The sample magnitude is its absolute value, and the most negative code reads as the largest positive magnitude (2^(SMP_W-1)-1).
- R3: In dynamic mode, each tick sets `fsw_high` on the next clock to 1 when the magnitude is at or above the frequency level and to 0 when it is below, with no hold.
- R4: In dynamic mode, a tick whose magnitude is at or above the rail level sets `rail_full` to 1 on the next clock, the same latency as `fsw_high`, and restarts the quiet count.
- R5: In dynamic mode, `rail_full` falls only on the clock after the N-th consecutive tick below the rail level, where N is the hold register (0 acts as 1). The count saturates and never wraps.
- R6: In dynamic mode, a clock with no tick and no write leaves both outputs unchanged.
- R7: Writing address 3 with bit 0 = 1 enters static mode. From the second clock edge after the write, `fsw_high` is 1 and `rail_full` equals bit 1 of that word (0 = half, 1 = full), whatever the samples.
- R8: Address 0 holds the frequency level, address 1 the rail level, address 2 the hold tick count. After reset these hold floor(10% of 2^(SMP_W-1)), floor(25% of 2^(SMP_W-1)) and HOLD_DEF.
- R9: On leaving static mode the outputs keep their static values until the next tick, and the quiet count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | One-cycle strobe: a new sample is on `smp_data` |
| smp_data | input | SMP_W | Signed two's-complement audio sample |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address (0 freq level, 1 rail level, 2 hold, 3 control) |
| cfg_wdata | input | CFG_W | Register write data |
| fsw_high | output | 1 | 1 = high pump switching frequency |
| rail_full | output | 1 | 1 = full supply rail, 0 = half supply rail |

## Verification
The assertions assume that `smp_vld` is a single-cycle strobe and that software writes registers only between ticks. They also assume that the rail level does not move while a quiet count is running. If it did, an expiry could fall on a tick judged against a different level. The stimulus keeps all writes apart from ticks, with an idle clock after each write. The sweeps run with the rail and frequency levels fixed, so every rise and fall of the outputs comes from a tick under one stable configuration.

// File: rtl/chsup_pkg.sv
package chsup_pkg;

  typedef enum logic [1:0] {
    REG_FREQ_LVL = 2'd0,
    REG_RAIL_LVL = 2'd1,
    REG_HOLD     = 2'd2,
    REG_CTRL     = 2'd3
  } reg_addr_e;

  // floor(pct percent of 2^(w-1)), full scale of a w-bit signed sample
  function automatic longint pct_of_fs(input int w, input int pct);
    longint fs;
    fs = longint'(1) <<< (w - 1);
    return (fs * pct) / 100;
  endfunction

  // hold limit: zero behaves as one tick
  function automatic longint hold_limit(input longint n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/chsup_regs.sv
module chsup_regs
  import chsup_pkg::*;
#(
  parameter int SMP_W    = 16,
  parameter int HOLD_W   = 16,
  parameter int CFG_W    = 16,
  parameter int HOLD_DEF = 1536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [CFG_W-1:0]  wdata,
  output logic [SMP_W-2:0]  lvl_freq,
  output logic [SMP_W-2:0]  lvl_rail,
  output logic [HOLD_W-1:0] hold_n,
  output logic              static_q,
  output logic              force_full
);

  localparam int MAG_W = SMP_W - 1;
  localparam logic [MAG_W-1:0]  FREQ_RST = MAG_W'(pct_of_fs(SMP_W, 10));
  localparam logic [MAG_W-1:0]  RAIL_RST = MAG_W'(pct_of_fs(SMP_W, 25));
  localparam logic [HOLD_W-1:0] HOLD_RST = HOLD_W'(HOLD_DEF);

  logic wr_freq, wr_rail, wr_hold, wr_ctrl;

  always_comb begin
    wr_freq = we && (addr == REG_FREQ_LVL);
    wr_rail = we && (addr == REG_RAIL_LVL);
    wr_hold = we && (addr == REG_HOLD);
    wr_ctrl = we && (addr == REG_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_freq   <= FREQ_RST;
      lvl_rail   <= RAIL_RST;
      hold_n     <= HOLD_RST;
      static_q   <= 1'b0;
      force_full <= 1'b0;
    end else begin
      if (wr_freq) lvl_freq <= wdata[MAG_W-1:0];
      if (wr_rail) lvl_rail <= wdata[MAG_W-1:0];
      if (wr_hold) hold_n   <= wdata[HOLD_W-1:0];
      if (wr_ctrl) begin
        static_q   <= wdata[0];
        force_full <= wdata[1];
      end
    end
  end

  // R7
  ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (static_q == $past(wdata[0])) && (force_full == $past(wdata[1])));

endmodule

// File: rtl/chsup_level.sv
module chsup_level #(
  parameter int SMP_W = 16
) (
  input  logic [SMP_W-1:0] sample,
  input  logic [SMP_W-2:0] lvl_freq,
  input  logic [SMP_W-2:0] lvl_rail,
  output logic [SMP_W-2:0] mag,
  output logic             ge_freq,
  output logic             ge_rail
);

  localparam int MAG_W = SMP_W - 1;
  localparam logic [SMP_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  function automatic logic [MAG_W-1:0] abs_sat(input logic [SMP_W-1:0] x);
    logic [SMP_W-1:0] neg;
    if (x == MOST_NEG) return {MAG_W{1'b1}};
    neg = ~x + 1'b1;
    return x[SMP_W-1] ? neg[MAG_W-1:0] : x[MAG_W-1:0];
  endfunction

  always_comb begin
    mag     = abs_sat(sample);
    ge_freq = (mag >= lvl_freq);
    ge_rail = (mag >= lvl_rail);
  end

  // R2
  always_comb begin
    mag_sign_chk: assert (!(sample[SMP_W-1] == 1'b0 && mag != sample[MAG_W-1:0]));
  end

endmodule

// File: rtl/chsup_hold.sv
module chsup_hold
  import chsup_pkg::*;
#(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ge_rail,
  input  logic              static_q,
  input  logic              force_full,
  input  logic [HOLD_W-1:0] hold_n,
  output logic              rail_full,
  output logic              hold_expire
);

  logic [HOLD_W-1:0] quiet_cnt;
  logic [HOLD_W-1:0] cnt_inc;
  logic [HOLD_W-1:0] limit;
  logic              dyn_tick;

  always_comb begin
    dyn_tick    = tick && !static_q;
    cnt_inc     = (quiet_cnt == {HOLD_W{1'b1}}) ? quiet_cnt : quiet_cnt + 1'b1;
    limit       = HOLD_W'(hold_limit(longint'(hold_n)));
    hold_expire = dyn_tick && !ge_rail && (cnt_inc >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_full <= 1'b1;
      quiet_cnt <= '0;
    end else if (static_q) begin
      rail_full <= force_full;
      quiet_cnt <= '0;
    end else if (dyn_tick) begin
      if (ge_rail) begin
        rail_full <= 1'b1;
        quiet_cnt <= '0;
      end else begin
        quiet_cnt <= cnt_inc;
        if (hold_expire) rail_full <= 1'b0;
      end
    end
  end

  // R4
  rail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_tick && ge_rail) |=> rail_full);

  // R5
  rail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rail_full) && !$past(static_q)) |-> $past(hold_expire));

  // R7
  rail_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    static_q |=> (rail_full == $past(force_full)));

endmodule

// File: rtl/chsup_ctrl.sv
module chsup_ctrl
  import chsup_pkg::*;
#(
  parameter int SMP_W    = 16,
  parameter int HOLD_W   = 16,
  parameter int HOLD_DEF = 1536,
  parameter int CFG_W    = ((SMP_W - 1) > HOLD_W) ? (SMP_W - 1) : HOLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             fsw_high,
  output logic             rail_full
);

  localparam int MAG_W = SMP_W - 1;

  logic [MAG_W-1:0]  lvl_freq, lvl_rail, mag;
  logic [HOLD_W-1:0] hold_n;
  logic              static_q, force_full;
  logic              ge_freq, ge_rail, hold_expire;

  chsup_regs #(
    .SMP_W(SMP_W), .HOLD_W(HOLD_W), .CFG_W(CFG_W), .HOLD_DEF(HOLD_DEF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .lvl_freq(lvl_freq), .lvl_rail(lvl_rail), .hold_n(hold_n),
    .static_q(static_q), .force_full(force_full)
  );

  chsup_level #(.SMP_W(SMP_W)) u_level (
    .sample(smp_data), .lvl_freq(lvl_freq), .lvl_rail(lvl_rail),
    .mag(mag), .ge_freq(ge_freq), .ge_rail(ge_rail)
  );

  chsup_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(smp_vld), .ge_rail(ge_rail),
    .static_q(static_q), .force_full(force_full), .hold_n(hold_n),
    .rail_full(rail_full), .hold_expire(hold_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fsw_high <= 1'b1;
    else if (static_q)  fsw_high <= 1'b1;
    else if (smp_vld)   fsw_high <= ge_freq;
  end

  // R3
  freq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !static_q) |=> (fsw_high == $past(ge_freq)));

  // R7
  freq_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    static_q |=> fsw_high);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !cfg_we && !static_q) |=> ($stable(fsw_high) && $stable(rail_full)));

endmodule

// File: tb/sim_chsup_ctrl.sv
module sim_chsup_ctrl;

  localparam int W  = 8;
  localparam int HW = 8;
  localparam int HD = 5;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_vld = 1'b0;
  logic [W-1:0]  smp_data = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          fsw_high, rail_full;

  int total = 0, bad = 0;
  int m_rail, m_fsw, m_cnt;
  int t_freq, t_rail, t_hold, m_stat, m_force;
  bit done = 0;

  always #2 clk = ~clk;

  chsup_ctrl #(.SMP_W(W), .HOLD_W(HW), .HOLD_DEF(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fsw_high(fsw_high), .rail_full(rail_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string rf, input string rr);
    chk(rf, int'(fsw_high), m_fsw);
    chk(rr, int'(rail_full), m_rail);
  endtask

  // one sample tick, outputs checked one clock later
  task automatic tick(input int v);
    int m, lim;
    @(negedge clk);
    smp_vld  = 1'b1;
    smp_data = W'(v);
    @(negedge clk);
    smp_vld  = 1'b0;
    m = (v == -128) ? 127 : ((v < 0) ? -v : v);   // R2
    if (m_stat == 0) begin
      m_fsw = (m >= t_freq) ? 1 : 0;
      if (m >= t_rail) begin
        m_rail = 1; m_cnt = 0;
      end else begin
        m_cnt = (m_cnt < 255) ? m_cnt + 1 : 255;
        lim = (t_hold == 0) ? 1 : t_hold;
        if (m_cnt >= lim) m_rail = 0;
      end
    end
    check_outs("R2 R3", "R4 R5");
  endtask

  task automatic idle();
    @(negedge clk);
    check_outs("R6", "R6");
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = CW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      0: t_freq = d;
      1: t_rail = d;
      2: t_hold = d;
      default: begin m_stat = d & 1; m_force = (d >> 1) & 1; end
    endcase
    @(negedge clk);
    if (m_stat != 0) begin m_rail = m_force; m_fsw = 1; m_cnt = 0; end
    check_outs("R7 R9", "R7 R9");
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8 reset values computed here: 10% and 25% of 128
    t_freq = (128 * 10) / 100; t_rail = (128 * 25) / 100; t_hold = HD;
    m_stat = 0; m_force = 0; m_rail = 1; m_fsw = 1; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1", "R1");

    // R8: threshold boundaries at reset values
    tick(11); chk("R8", int'(fsw_high), 0);
    tick(-12); chk("R8", int'(fsw_high), 1);
    tick(-32); chk("R8", int'(rail_full), 1);

    // full sweep with default registers
    for (int v = -128; v < 128; v++) begin
      tick(v);
      if ((v & 15) == 0) idle();
    end
    // quiet stretch: default hold expires
    for (int i = 0; i < HD + 1; i++) tick(31);

    // new levels and hold length, descending sweep
    wr(0, 50); wr(1, 100); wr(2, 3);
    for (int v = 127; v >= -128; v--) begin
      tick(v);
      if ((v & 7) == 0) idle();
    end

    // R5: restart and exact fall point
    tick(-128); chk("R5", int'(rail_full), 1);
    tick(0); tick(99); chk("R5", int'(rail_full), 1);
    tick(100); tick(5); tick(5); chk("R5", int'(rail_full), 1);
    tick(5); chk("R5", int'(rail_full), 0);

    // R5: hold of zero acts as one tick
    wr(2, 0);
    tick(120); tick(1); chk("R5", int'(rail_full), 0);

    // R7: static half, then static full
    wr(3, 1);
    tick(-128); chk("R7", int'(rail_full), 0); chk("R7", int'(fsw_high), 1);
    wr(3, 3);
    tick(0); chk("R7", int'(rail_full), 1); idle();

    // R9: leave static, outputs hold, count restarts
    wr(2, 4);
    wr(3, 0); chk("R9", int'(rail_full), 1);
    idle();
    for (int i = 0; i < 3; i++) tick(10);
    chk("R9", int'(rail_full), 1);
    tick(10); chk("R9", int'(rail_full), 0);
    chk("R3", int'(fsw_high), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule